// File: doc/BRIEF.md
# Dual Snapshot Down-Counter Timers

Two 32-bit down-counting timers sit behind one byte-wide register port. Each timer has a control register, a mode register and four data byte registers. A timer counts down once for every pulse on a shared tick input while it is enabled. A tick that finds the count at zero reloads the count from a programmable load value and sets a sticky terminal flag. That flag drives the timer's interrupt line when the timer's interrupt enable is set.

Software can only read a wide count one byte at a time. To keep such a read coherent, reading a timer's lowest data byte copies the whole live count into a snapshot register. The later byte reads return bytes of that snapshot. A mode bit held in timer 0 widens this, so that one read of timer 0's lowest byte snapshots every timer in the same cycle. A separate source bit in each timer makes data reads return the load value instead of the count. Data byte writes always go to the load value, whatever the source bit says.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every control bit, load value, count and snapshot is zero, every irq_o bit is low and rdata_o is 0x00.
- R2: Timer t owns addresses 8*t to 8*t+7. The offsets are: 0 is the control register (bit0 enable, bit1 interrupt enable, bit2 terminal flag, bit3 source select); 1 is the mode register (bit0 snapshot-all, kept only in timer 0, so other timers read 0 there and ignore writes); 4 to 7 are data bytes, offset 4 holding count bits 7..0 and each higher offset the next byte up. Read data appears on rdata_o in the cycle after rd_en_i and holds while no read is issued.
- R3: A write to a data byte updates only that byte of the load value, whatever the source bit holds; the running count is not changed by it.
- R4: With the source bit at 1, data byte reads return bytes of the load value.
- R5: A control write that turns enable from 0 to 1 copies the load value into the count.
- R6: Each tick while enabled lowers the count by one; ticks while disabled leave it unchanged.
- R7: A tick while enabled with the count at zero reloads the count from the load value and sets the terminal flag.
- R8: Writing 1 to control bit2 clears the terminal flag; writing 0 there leaves it set; a flag set in the same cycle wins.
- R9: irq_o[t] is high exactly while timer t's terminal flag and interrupt enable are both set.
- R10: With snapshot-all at 0, a read of a timer's offset 4 copies its live count into its own snapshot, whatever the source bit holds, and returns that count's low byte; reads of offsets 5 to 7 return snapshot bytes.
- R11: With snapshot-all at 1, a read of timer 0's offset 4 snapshots every timer at once, and a read of another timer's offset 4 takes no new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable pulse shared by all timers |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (4) | Register address: timer index above, offset in bits 2..0 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | NUM_TMR (2) | Per-timer interrupt |

## Verification
A wrong count or load shows up on the next read of a data byte, one cycle after the read strobe. A stale or wrongly timed snapshot shows up only when a read of an upper byte follows ticks that have changed the live count. For that reason the bench changes the count between a low-byte read and the upper-byte reads, and it picks values where those bytes differ. A terminal flag that is wrong shows up on irq_o in the same cycle it is set, and on the next control read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned REG_STRIDE = 8;
    localparam logic [2:0]  OFF_CTRL   = 3'd0;
    localparam logic [2:0]  OFF_MODE   = 3'd1;
    localparam logic [2:0]  OFF_DATA0  = 3'd4;

    typedef struct packed {
        logic src;
        logic tc;
        logic ie;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/tmr_rdsel.sv
module tmr_rdsel #(
    parameter int unsigned NUM_TMR = 2,
    parameter int unsigned IDX_W   = 1
) (
    input  logic [NUM_TMR*8-1:0] bytes_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [7:0]           byte_o
);
    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (idx_i == IDX_W'(i)) begin
                byte_o = bytes_i[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_BYTES = 4,
    parameter bit          IS_MASTER = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [2:0] off_i,
    input  logic [7:0] wdata_i,
    input  logic       glob_i,
    input  logic       glob_latch_i,
    output logic [7:0] rd_byte_o,
    output logic       irq_o,
    output logic       glob_o
);
    localparam int unsigned CNT_W  = 8 * CNT_BYTES;
    localparam logic [2:0]  NBYTES = 3'(CNT_BYTES);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              glob;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  snap;
    } state_t;

    state_t s_d, s_q;

    logic             byte_ok;
    logic [1:0]       bidx;
    logic             trig;
    logic             en_rise;
    logic [CNT_W-1:0] view;
    logic [CNT_W-1:0] shifted;

    always_comb begin
        s_d     = s_q;
        bidx    = off_i[1:0];
        byte_ok = off_i[2] && ({1'b0, bidx} < NBYTES);
        trig    = (rd_en_i && off_i == OFF_DATA0 && !glob_i) || glob_latch_i;
        en_rise = 1'b0;

        if (trig) begin
            s_d.snap = s_q.cnt;
        end

        if (wr_en_i && byte_ok) begin
            for (int b = 0; b < CNT_BYTES; b++) begin
                if (bidx == 2'(b)) begin
                    s_d.load[8*b +: 8] = wdata_i;
                end
            end
        end

        if (wr_en_i && off_i == OFF_CTRL) begin
            s_d.ctrl.en  = wdata_i[0];
            s_d.ctrl.ie  = wdata_i[1];
            s_d.ctrl.src = wdata_i[3];
            if (wdata_i[2]) begin
                s_d.ctrl.tc = 1'b0;
            end
            en_rise = wdata_i[0] && !s_q.ctrl.en;
        end

        if (IS_MASTER && wr_en_i && off_i == OFF_MODE) begin
            s_d.glob = wdata_i[0];
        end

        if (en_rise) begin
            s_d.cnt = s_q.load;
        end else if (tick_i && s_q.ctrl.en) begin
            if (s_q.cnt == '0) begin
                s_d.cnt     = s_q.load;
                s_d.ctrl.tc = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end

        view      = s_q.ctrl.src ? s_q.load : (trig ? s_q.cnt : s_q.snap);
        shifted   = view >> {bidx, 3'b000};
        rd_byte_o = 8'h00;
        if (off_i == OFF_CTRL) begin
            rd_byte_o = {4'b0000, s_q.ctrl};
        end else if (off_i == OFF_MODE) begin
            rd_byte_o = {7'b0000000, s_q.glob};
        end else if (byte_ok) begin
            rd_byte_o = shifted[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o  = s_q.ctrl.tc && s_q.ctrl.ie;
    assign glob_o = s_q.glob;

    // R7
    reload_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && s_q.ctrl.en && s_q.cnt == '0) |=> (s_q.cnt == $past(s_q.load) && s_q.ctrl.tc));

    // R6
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && s_q.ctrl.en && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(wr_en_i && off_i == OFF_CTRL)) |=> $stable(s_q.cnt));

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en_i && off_i == OFF_DATA0) && !glob_latch_i) |=> $stable(s_q.snap));

    // R8
    tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.tc && !(wr_en_i && off_i == OFF_CTRL && wdata_i[2])) |=> s_q.ctrl.tc);

    // R3
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && off_i[2]) |=> $stable(s_q.load));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_TMR   = 2,
    parameter int unsigned CNT_BYTES = 4,
    localparam int unsigned IDX_W    = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
    localparam int unsigned ADDR_W   = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic [NUM_TMR-1:0] irq_o
);
    typedef struct packed {
        logic [7:0] rdata;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [IDX_W-1:0]     tidx;
    logic [2:0]           off;
    logic [NUM_TMR-1:0]   glob_w;
    logic                 glob;
    logic                 glob_latch;
    logic [NUM_TMR*8-1:0] bytes_w;
    logic [7:0]           sel_byte;

    assign tidx       = addr_i[ADDR_W-1:3];
    assign off        = addr_i[2:0];
    assign glob       = |glob_w;
    assign glob_latch = rd_en_i && tidx == '0 && off == OFF_DATA0 && glob;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tmr_unit #(
            .CNT_BYTES (CNT_BYTES),
            .IS_MASTER (g == 0)
        ) u_tmr (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick_i       (tick_i),
            .wr_en_i      (wr_en_i && tidx == IDX_W'(g)),
            .rd_en_i      (rd_en_i && tidx == IDX_W'(g)),
            .off_i        (off),
            .wdata_i      (wdata_i),
            .glob_i       (glob),
            .glob_latch_i (glob_latch),
            .rd_byte_o    (bytes_w[8*g +: 8]),
            .irq_o        (irq_o[g]),
            .glob_o       (glob_w[g])
        );
    end

    tmr_rdsel #(
        .NUM_TMR (NUM_TMR),
        .IDX_W   (IDX_W)
    ) u_rdsel (
        .bytes_i (bytes_w),
        .idx_i   (tidx),
        .byte_o  (sel_byte)
    );

    always_comb begin
        t_d = t_q;
        if (rd_en_i) begin
            t_d.rdata = sel_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign rdata_o = t_q.rdata;

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

    // R2
    glob_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(glob_w) <= 1);
endmodule

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [3:0] addr_i = 4'h0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic [1:0] irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    tmr_pair u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    always @(posedge clk) rd_seen <= rd_en_i;

    // monitor: compares registered read data against the scoreboard
    always @(negedge clk) begin
        if (rd_seen) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with no expected item, got %02h", rdata_o);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata_o !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %02h expected %02h", t, rdata_o, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic [1:0] e, input string t);
        @(negedge clk);
        n_chk++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (rdata_o !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: rdata actual %02h expected 00", rdata_o);
        end
        rst_n = 1'b1;
        chk_irq(2'b00, "R1 irq");
        rd(4'h0, 8'h00, "R1 ctrl t0");
        rd(4'h1, 8'h00, "R1 mode t0");
        rd(4'h4, 8'h00, "R1 count t0");

        // R2 / R4: byte order of load value
        wr(4'h4, 8'h78); wr(4'h5, 8'h56); wr(4'h6, 8'h34); wr(4'h7, 8'h12);
        wr(4'h0, 8'h08);
        rd(4'h4, 8'h78, "R4 byte0");
        rd(4'h5, 8'h56, "R2 byte1");
        rd(4'h6, 8'h34, "R2 byte2");
        rd(4'h7, 8'h12, "R2 byte3");

        // R5 / R6 / R10: preload, count and snapshot
        wr(4'h4, 8'h02); wr(4'h5, 8'h01); wr(4'h6, 8'h00); wr(4'h7, 8'h00);
        wr(4'h0, 8'h01);
        tk(2);
        rd(4'h4, 8'h00, "R10 low byte at 0x100");
        tk(1);
        rd(4'h5, 8'h01, "R10 snapshot byte1");
        rd(4'h4, 8'hFF, "R6 low byte at 0x0FF");
        rd(4'h5, 8'h00, "R10 new snapshot byte1");
        wr(4'h0, 8'h00);
        tk(3);
        rd(4'h4, 8'hFF, "R6 disabled hold");

        // R7 / R9: terminal count on timer 1
        wr(4'hC, 8'h03); wr(4'hD, 8'h00); wr(4'hE, 8'h00); wr(4'hF, 8'h00);
        wr(4'h8, 8'h03);
        tk(3);
        chk_irq(2'b00, "R9 before terminal");
        rd(4'hC, 8'h00, "R6 count reached zero");
        tk(1);
        chk_irq(2'b10, "R9 after terminal");
        rd(4'h8, 8'h07, "R7 flag set");
        rd(4'hC, 8'h03, "R7 reloaded");

        // R8: write-one-to-clear
        wr(4'h8, 8'h03);
        rd(4'h8, 8'h07, "R8 zero keeps flag");
        wr(4'h8, 8'h07);
        rd(4'h8, 8'h03, "R8 one clears flag");
        chk_irq(2'b00, "R9 cleared");
        wr(4'h8, 8'h01);
        tk(4);
        chk_irq(2'b00, "R9 ie off");
        rd(4'h8, 8'h05, "R7 flag with ie off");
        wr(4'h8, 8'h05);
        rd(4'h8, 8'h01, "R8 clear again");

        // R11: snapshot-all mode, timer1 count 3, timer0 0xFF
        wr(4'h9, 8'h01);
        rd(4'h9, 8'h00, "R2 mode ignored in timer1");
        wr(4'h1, 8'h01);
        rd(4'h1, 8'h01, "R2 mode readback t0");
        rd(4'h4, 8'hFF, "R11 t0 low read");
        tk(1);
        rd(4'hC, 8'h03, "R11 t1 shows global snapshot");
        rd(4'hC, 8'h03, "R11 t1 low read takes no snapshot");
        rd(4'h4, 8'hFF, "R11 t0 low read again");
        rd(4'hC, 8'h02, "R11 t1 resnapped");

        // R10: back to local mode
        wr(4'h1, 8'h00);
        tk(1);
        rd(4'hC, 8'h01, "R10 t1 local snapshot");

        // R3: load write while reading counts
        wr(4'hD, 8'h01);
        rd(4'hC, 8'h01, "R3 count untouched by load write");
        tk(2);
        rd(4'hC, 8'h03, "R3 reload low byte");
        rd(4'hD, 8'h01, "R3 reload byte1");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule